// File: doc/BRIEF.md
# Dual-Plane Flash Status Reporter

This block sits in the read path of a two-plane flash array controller. It builds the word returned to the host while an embedded program or erase is running. Reads that hit the busy plane get a status word instead of array contents. Bit 7 works as a polling bit. Bit 6 flips on every read of the busy plane. Bit 2 flips on reads of the erasing plane, or of a sector whose erase is on hold. Reads of the other plane, and reads after the operation has finished, return the array word unchanged. An active-low ready/busy output is low for as long as a program or erase runs.

The controller supplies these inputs:
- the current operation kind;
- the plane that operation works in;
- whether an erase is suspended, and which sector it is in;
- bit 7 of the last word loaded for programming;
- the sector field of the read address, and a one-cycle read strobe;
- the array word read at that address.

The status word is registered on the strobe edge. It holds until the next strobe.

Top module: `dual_plane_status`

## Requirements
- R1: While `rst_n` is low at a clock edge, `rd_data` becomes 0 and `busy_n` becomes 1. The toggle state is cleared.
- R2: `busy_n` is low in the cycle after any cycle where `op_kind` is 1 (program) or 2 (erase). It is high after any cycle where `op_kind` is 0 (idle) or 3 (reserved, treated as idle), whether or not an erase is suspended.
- R3: During a program with no erase suspended, a strobed read whose plane matches `op_plane` returns these values. The plane is the MSB of `rd_sect`. Bit 7 is the inverse of `last_bit7`. Bit 2 is 1. Bit 6 is the bit-6 toggle. All other bits come from `array_data`.
- R4: During an erase, a strobed read of the erasing plane returns 0 on bit 7. Bit 6 is the bit-6 toggle and bit 2 is the bit-2 toggle. All other bits come from `array_data`.
- R5: Each strobed read that gets a status word with a toggling bit returns the current value of that toggle, then inverts it. The first such read after an operation start returns 0. Cycles without a strobe leave the toggles unchanged.
- R6: While a program or erase runs, a strobed read of the other plane returns `array_data` on every bit. This holds as long as the read does not hit a suspended sector.
- R7: A read hits the suspended sector when `susp_valid` is 1, `rd_sect` equals `susp_sect`, and R3, R4 and R8 do not apply. Such a read returns 1 on bits 7 and 6 and the bit-2 toggle on bit 2. Reads of other sectors return `array_data`.
- R8: During a program while an erase is suspended, a strobed read of the programming plane returns the inverse of `last_bit7` on bit 7. Bits 6 and 2 carry their toggles, and both toggles advance.
- R9: A cycle with `op_start` high clears both toggles. A read strobed in that same cycle reports the cleared value 0 and does not advance any toggle.
- R10: With `op_kind` idle and `susp_valid` 0, a strobed read returns `array_data` on every bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | One-cycle pulse when a new program or erase begins |
| op_kind | input | 2 | 0 idle, 1 program, 2 erase, 3 reserved (idle) |
| op_plane | input | 1 | Plane the running operation works in |
| susp_valid | input | 1 | An erase is suspended |
| susp_sect | input | SECT_W | Sector of the suspended erase |
| last_bit7 | input | 1 | Bit 7 of the last word loaded for programming |
| rd_strobe | input | 1 | One-cycle read strobe |
| rd_sect | input | SECT_W | Sector field of the read address; MSB selects the plane |
| array_data | input | DATA_W | Array word at the read address |
| rd_data | output | DATA_W | Registered read result |
| busy_n | output | 1 | Low while a program or erase runs |

## Verification
A toggle flip-flop stuck or advanced on the wrong read appears as a repeated or skipped bit-6 or bit-2 value. This shows on the next strobed status read, one cycle after its strobe. A misclassified read shows as status bits replacing array data, or the reverse, on that same read. A wrong busy state shows on `busy_n` one cycle after the operation kind changes. The stimulus mixes plane, sector and operation kind at random, so every classification meets every toggle phase.

// File: rtl/dps_pkg.sv
// Shared types for the dual-plane status reporter.
package dps_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_RSVD  = 2'd3
    } op_kind_e;

    typedef enum logic [2:0] {
        CLS_ARRAY,
        CLS_PROG,
        CLS_ERASE,
        CLS_SUSP,
        CLS_PROG_SUSP
    } rd_class_e;
endpackage

// File: rtl/dps_read_classify.sv
// Decides what kind of word a read at the given sector should return.
// Assumes: the plane is the MSB of the sector field. An erase is never
// reported together with a suspended erase.
module dps_read_classify
    import dps_pkg::*;
#(
    parameter int SECT_W = 4
) (
    input  logic [1:0]        op_kind,
    input  logic              op_plane,
    input  logic              susp_valid,
    input  logic [SECT_W-1:0] susp_sect,
    input  logic [SECT_W-1:0] rd_sect,
    output rd_class_e         cls
);
    logic plane_hit;
    logic sect_hit;

    assign plane_hit = (rd_sect[SECT_W-1] == op_plane);
    assign sect_hit  = susp_valid && (rd_sect == susp_sect);

    // Busy-plane cases take priority over the suspended-sector case.
    always_comb begin
        cls = CLS_ARRAY;
        if (op_kind == OP_PROG && plane_hit) begin
            cls = susp_valid ? CLS_PROG_SUSP : CLS_PROG;
        end else if (op_kind == OP_ERASE && plane_hit) begin
            cls = CLS_ERASE;
        end else if (sect_hit) begin
            cls = CLS_SUSP;
        end
    end
endmodule

// File: rtl/dps_toggle_bank.sv
// A bank of toggle flip-flops that advance on qualified reads.
// Assumes: clear has priority over advance. The value seen in a clear
// cycle is already the cleared value.
module dps_toggle_bank #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic [N-1:0] adv,
    output logic [N-1:0] eff
);
    logic [N-1:0] q;

    for (genvar i = 0; i < N; i++) begin : g_tgl
        // Holds one toggle; reset and clear load 0, a qualified read inverts.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                q[i] <= 1'b0;
            end else if (adv[i]) begin
                q[i] <= ~q[i];
            end
        end
        assign eff[i] = clear ? 1'b0 : q[i];
    end
endmodule

// File: rtl/dps_status_mux.sv
// Composes the word returned for a read from its class, the toggles and
// the array word.
// Assumes: DATA_W >= 8.
module dps_status_mux
    import dps_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  rd_class_e         cls,
    input  logic              t6,
    input  logic              t2,
    input  logic              last_bit7,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] word
);
    // Overlays bits 7, 6 and 2 according to the read class.
    always_comb begin
        word = array_data;
        unique case (cls)
            CLS_PROG: begin
                word[7] = ~last_bit7;
                word[6] = t6;
                word[2] = 1'b1;
            end
            CLS_PROG_SUSP: begin
                word[7] = ~last_bit7;
                word[6] = t6;
                word[2] = t2;
            end
            CLS_ERASE: begin
                word[7] = 1'b0;
                word[6] = t6;
                word[2] = t2;
            end
            CLS_SUSP: begin
                word[7] = 1'b1;
                word[6] = 1'b1;
                word[2] = t2;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dual_plane_status.sv
// Top of the status reporter. It registers the read word on each strobe
// and drives ready/busy from the current operation kind.
// Assumes: op_start is a single-cycle pulse. rd_strobe marks a completed
// read of the word on array_data.
module dual_plane_status
    import dps_pkg::*;
#(
    parameter int SECT_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic [1:0]        op_kind,
    input  logic              op_plane,
    input  logic              susp_valid,
    input  logic [SECT_W-1:0] susp_sect,
    input  logic              last_bit7,
    input  logic              rd_strobe,
    input  logic [SECT_W-1:0] rd_sect,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy_n
);
    localparam int NTGL = 2;
    localparam int T6   = 0;
    localparam int T2   = 1;

    rd_class_e         cls;
    logic [NTGL-1:0]   adv;
    logic [NTGL-1:0]   eff;
    logic [DATA_W-1:0] word;
    logic              running;

    dps_read_classify #(.SECT_W(SECT_W)) u_cls (
        .op_kind   (op_kind),
        .op_plane  (op_plane),
        .susp_valid(susp_valid),
        .susp_sect (susp_sect),
        .rd_sect   (rd_sect),
        .cls       (cls)
    );

    // Selects which toggles a strobed read of this class advances.
    always_comb begin
        adv[T6] = rd_strobe && (cls == CLS_PROG || cls == CLS_ERASE ||
                                cls == CLS_PROG_SUSP);
        adv[T2] = rd_strobe && (cls == CLS_ERASE || cls == CLS_SUSP ||
                                cls == CLS_PROG_SUSP);
    end

    dps_toggle_bank #(.N(NTGL)) u_tgl (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(op_start),
        .adv  (adv),
        .eff  (eff)
    );

    dps_status_mux #(.DATA_W(DATA_W)) u_mux (
        .cls       (cls),
        .t6        (eff[T6]),
        .t2        (eff[T2]),
        .last_bit7 (last_bit7),
        .array_data(array_data),
        .word      (word)
    );

    assign running = (op_kind == OP_PROG) || (op_kind == OP_ERASE);

    // Captures the composed word on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_strobe) begin
            rd_data <= word;
        end
    end

    // Drives ready/busy low while a program or erase runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_n <= 1'b1;
        end else begin
            busy_n <= ~running;
        end
    end
endmodule

// File: rtl/dps_checker.sv
// Port-level properties of the status reporter, bound to the top module.
module dps_checker #(
    parameter int SECT_W = 4,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_start,
    input logic [1:0]        op_kind,
    input logic              op_plane,
    input logic              susp_valid,
    input logic [SECT_W-1:0] susp_sect,
    input logic              last_bit7,
    input logic              rd_strobe,
    input logic [SECT_W-1:0] rd_sect,
    input logic [DATA_W-1:0] array_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              busy_n
);
    logic same_plane;
    assign same_plane = (rd_sect[SECT_W-1] == op_plane);

    AST_BUSY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == 2'd1 || op_kind == 2'd2) |=> !busy_n); // R2
    AST_BUSY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == 2'd0 || op_kind == 2'd3) |=> busy_n); // R2
    AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && op_kind == 2'd1 && same_plane)
        |=> (rd_data[7] == ~$past(last_bit7))); // R3
    AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && op_kind == 2'd2 && same_plane) |=> (rd_data[7] == 1'b0)); // R4
    AST_OTHER_PLANE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && op_kind != 2'd0 && op_kind != 2'd3 && !same_plane && !susp_valid)
        |=> (rd_data == $past(array_data))); // R6
    AST_SUSP_SECT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && (op_kind == 2'd0 || op_kind == 2'd3) && susp_valid && rd_sect == susp_sect)
        |=> (rd_data[7:6] == 2'b11)); // R7
    AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && op_start && op_kind == 2'd2 && same_plane)
        |=> (rd_data[6] == 1'b0 && rd_data[2] == 1'b0)); // R9
    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && (op_kind == 2'd0 || op_kind == 2'd3) && !susp_valid)
        |=> (rd_data == $past(array_data))); // R10
endmodule

bind dual_plane_status dps_checker #(.SECT_W(SECT_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_start  (op_start),
    .op_kind   (op_kind),
    .op_plane  (op_plane),
    .susp_valid(susp_valid),
    .susp_sect (susp_sect),
    .last_bit7 (last_bit7),
    .rd_strobe (rd_strobe),
    .rd_sect   (rd_sect),
    .array_data(array_data),
    .rd_data   (rd_data),
    .busy_n    (busy_n)
);

// File: tb/dual_plane_status_tb.sv
`timescale 1ns/1ps
module dual_plane_status_tb;
    localparam int SECT_W = 4;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              op_start;
    logic [1:0]        op_kind;
    logic              op_plane;
    logic              susp_valid;
    logic [SECT_W-1:0] susp_sect;
    logic              last_bit7;
    logic              rd_strobe;
    logic [SECT_W-1:0] rd_sect;
    logic [DATA_W-1:0] array_data;
    logic [DATA_W-1:0] rd_data;
    logic              busy_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic m6 = 1'b0;
    logic m2 = 1'b0;

    always #10 clk = ~clk;

    dual_plane_status #(.SECT_W(SECT_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
        .op_plane(op_plane), .susp_valid(susp_valid), .susp_sect(susp_sect),
        .last_bit7(last_bit7), .rd_strobe(rd_strobe), .rd_sect(rd_sect),
        .array_data(array_data), .rd_data(rd_data), .busy_n(busy_n)
    );

    // Read class: 0 array, 1 program, 2 erase, 3 suspended sector, 4 program in suspend
    function automatic int read_class(logic [1:0] k, logic pl, logic sv,
                                      logic [SECT_W-1:0] ss, logic [SECT_W-1:0] rs);
        bit busy_plane = (rs[SECT_W-1] == pl);
        if (k == 2'd1 && busy_plane) return sv ? 4 : 1;
        if (k == 2'd2 && busy_plane) return 2;
        if (sv && rs == ss) return 3;
        return 0;
    endfunction

    function automatic string class_tag(int c, logic [1:0] k);
        case (c)
            1: return "R3/R5";
            2: return "R4/R5";
            3: return "R7";
            4: return "R8";
            default: return (k == 2'd1 || k == 2'd2) ? "R6" : "R10";
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] expect_word(int c, logic t6, logic t2,
                                                     logic lb, logic [DATA_W-1:0] ad);
        logic [DATA_W-1:0] w = ad;
        if (c == 1 || c == 4) begin w[7] = ~lb; w[6] = t6; w[2] = (c == 1) ? 1'b1 : t2; end
        if (c == 2) begin w[7] = 1'b0; w[6] = t6; w[2] = t2; end
        if (c == 3) begin w[7] = 1'b1; w[6] = 1'b1; w[2] = t2; end
        return w;
    endfunction

    task automatic check(bit ok, string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at a falling edge, check at the next falling edge.
    task automatic step(logic st, logic [1:0] k, logic pl, logic sv, logic [SECT_W-1:0] ss,
                        logic lb, logic rs, logic [SECT_W-1:0] sect, logic [DATA_W-1:0] ad);
        int c;
        logic t6, t2;
        logic [DATA_W-1:0] exp;
        string tag;
        op_start = st; op_kind = k; op_plane = pl; susp_valid = sv; susp_sect = ss;
        last_bit7 = lb; rd_strobe = rs; rd_sect = sect; array_data = ad;
        c   = read_class(k, pl, sv, ss, sect);
        t6  = st ? 1'b0 : m6;
        t2  = st ? 1'b0 : m2;
        exp = expect_word(c, t6, t2, lb, ad);
        tag = st ? "R9" : class_tag(c, k);
        @(negedge clk);
        check(busy_n == !(k == 2'd1 || k == 2'd2), "R2", {{(DATA_W-1){1'b0}}, busy_n},
              {{(DATA_W-1){1'b0}}, !(k == 2'd1 || k == 2'd2)});
        if (rs) check(rd_data == exp, tag, rd_data, exp);
        if (st) begin
            m6 = 1'b0; m2 = 1'b0;
        end else if (rs) begin
            if (c == 1 || c == 2 || c == 4) m6 = ~m6;
            if (c == 2 || c == 3 || c == 4) m2 = ~m2;
        end
        rd_strobe = 1'b0;
        op_start  = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        rst_n = 1'b0; op_start = 1'b0; op_kind = 2'd1; op_plane = 1'b0;
        susp_valid = 1'b0; susp_sect = '0; last_bit7 = 1'b0;
        rd_strobe = 1'b1; rd_sect = '0; array_data = 16'hFFFF;
        repeat (3) @(negedge clk);
        // R1: reset state, even with a program requested and a strobe pending
        check(rd_data == '0, "R1", rd_data, '0);
        check(busy_n == 1'b1, "R1", {15'd0, busy_n}, 16'd1);
        rd_strobe = 1'b0;
        rst_n = 1'b1;

        // R5/R3: program in plane 0, toggle sequence 0,1,0 with idle gaps
        step(1, 2'd1, 0, 0, 4'h0, 1, 0, 4'h1, 16'h1234);
        step(0, 2'd1, 0, 0, 4'h0, 1, 1, 4'h2, 16'h00FF);
        step(0, 2'd1, 0, 0, 4'h0, 1, 0, 4'h2, 16'h00FF);
        step(0, 2'd1, 0, 0, 4'h0, 1, 1, 4'h3, 16'hAA55);
        step(0, 2'd1, 0, 0, 4'h0, 1, 1, 4'h3, 16'h0000);
        // R6: other plane during the program
        step(0, 2'd1, 0, 0, 4'h0, 1, 1, 4'h9, 16'hBEEF);
        // R4/R9: erase start with a same-cycle read, then two reads
        step(1, 2'd2, 1, 0, 4'h0, 0, 1, 4'hC, 16'hFFFF);
        step(0, 2'd2, 1, 0, 4'h0, 0, 1, 4'hC, 16'hFFFF);
        step(0, 2'd2, 1, 0, 4'h0, 0, 1, 4'hF, 16'hFFFF);
        // R7: suspended sector and its neighbour, idle otherwise
        step(0, 2'd0, 1, 1, 4'hC, 0, 1, 4'hC, 16'h0000);
        step(0, 2'd0, 1, 1, 4'hC, 0, 1, 4'hD, 16'h1357);
        // R8: program in the suspended plane
        step(1, 2'd1, 1, 1, 4'hC, 0, 0, 4'h0, 16'h0);
        step(0, 2'd1, 1, 1, 4'hC, 0, 1, 4'hE, 16'h0F0F);
        step(0, 2'd1, 1, 1, 4'hC, 0, 1, 4'hE, 16'h0F0F);
        // R10: completion returns array data; reserved kind is idle
        step(0, 2'd0, 1, 0, 4'hC, 0, 1, 4'hE, 16'hCAFE);
        step(0, 2'd3, 1, 0, 4'hC, 0, 1, 4'h8, 16'h5A5A);

        for (int op = 0; op < 300; op++) begin
            int mode;
            logic [1:0] k;
            logic pl, sv, lb;
            logic [SECT_W-1:0] ss;
            mode = $urandom % 4;
            pl = 1'($urandom);
            lb = 1'($urandom);
            ss = SECT_W'($urandom);
            k  = (mode == 0) ? 2'd0 : (mode == 2) ? 2'd2 : 2'd1;
            sv = (mode == 0 || mode == 3);
            step(1'($urandom % 2), k, pl, sv, ss, lb, 1'($urandom), SECT_W'($urandom),
                 DATA_W'($urandom));
            for (int r = 0; r < 8; r++) begin
                int am;
                logic [SECT_W-1:0] sect;
                am = $urandom % 3;
                sect = SECT_W'($urandom);
                if (am == 1) sect[SECT_W-1] = pl;
                if (am == 2) sect = ss;
                step(0, k, pl, sv, ss, lb, ($urandom % 4) != 0, sect, DATA_W'($urandom));
            end
            if ($urandom % 3 == 0)
                step(0, 2'd0, pl, 0, ss, lb, 1, SECT_W'($urandom), DATA_W'($urandom));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule